// File: doc/BRIEF.md
# SPI master with timed chip select

This block is a single-slave SPI master that performs one complete bus transaction for each accepted start request. A transaction opens with a command byte. That byte carries a 7-bit register address, most significant bit first, followed by a direction bit. One or more data bytes follow the command byte. For a write, the data bytes come from a payload vector captured at start. For a read, the master sends zeros on MOSI and hands each byte it receives from MISO to the host, with a one-cycle valid strobe per byte.

Chip select is timed in system clock cycles. It leads the first SCK rising edge by a fixed guard of LEAD_SYS cycles plus half an SCK period. It lags the last SCK falling edge by the same amount. Once it returns high it stays high for at least GAP_SYS cycles before the next transaction may begin. SCK is derived from the system clock by an integer divider of at least 2. Data leaves on falling edges and is sampled on rising edges. The MOSI driver enable is dropped at the final falling edge, so the line floats between transactions. The host sees a busy flag and a done pulse.

Top module: `spi_guard_master`

## Requirements
- R1: Out of reset, cs_n_o is 1 and sck_o, mosi_oe_o, busy_o, done_o and rd_valid_o are all 0.
- R2: From the clock in which cs_n_o falls to the clock in which sck_o first rises, exactly LEAD_SYS + ceil(DIV_SYS/2) system clocks pass (13 with the defaults).
- R3: From the clock in which sck_o falls for the last time to the clock in which cs_n_o rises, exactly LEAD_SYS + ceil(DIV_SYS/2) system clocks pass.
- R4: cs_n_o stays high for at least GAP_SYS clocks between transactions. A start held asserted through a transaction begins the next one exactly GAP_SYS clocks after cs_n_o rises.
- R5: sck_o is low whenever cs_n_o is high. Within a transaction every high phase lasts ceil(DIV_SYS/2) clocks and every low phase between pulses lasts DIV_SYS - ceil(DIV_SYS/2) clocks. A transaction with N data bytes has 8*(N+1) pulses.
- R6: The first byte on MOSI is {addr_i[6:0], rw_i}, sent MSB first, where rw_i = 1 means read. Write data byte k (k = 1..N) is wr_data_i[8k-1:8k-8], also MSB first.
- R7: While cs_n_o stays low and the driver is enabled, mosi_o changes only in the clock in which sck_o falls. MISO is sampled at the clock in which sck_o rises.
- R8: mosi_oe_o rises with cs_n_o falling and drops in the same clock as the final sck_o falling edge.
- R9: On a read, MOSI carries 0 during the data bytes. Each data byte received from MISO appears in order on rd_data_o with rd_valid_o high for one clock. The command byte and write transactions produce no rd_valid_o.
- R10: busy_o is high from the clock after acceptance until a new start can be taken. A start asserted while busy_o is high is ignored.
- R11: done_o is high for exactly one clock, the clock in which cs_n_o returns high.
- R12: A count of 0 on nbytes_i is handled as 1 data byte. A count above MAX_BYTES is handled as MAX_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transaction request, sampled when not busy |
| addr_i | input | 7 | Register address for the command byte |
| rw_i | input | 1 | Direction, 1 = read |
| wr_data_i | input | 8*MAX_BYTES | Write payload, byte 1 in bits [7:0] |
| nbytes_i | input | clog2(MAX_BYTES+1)+1 | Number of data bytes |
| rd_data_o | output | 8 | Received data byte |
| rd_valid_o | output | 1 | One-clock strobe per received data byte |
| busy_o | output | 1 | Transaction or guard time in progress |
| done_o | output | 1 | One-clock pulse when chip select returns high |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Driver enable for MOSI |
| miso_i | input | 1 | Serial data in |

## Verification
The main function is exercised with multi-byte writes, single-byte writes, a three-byte read and clamped byte counts (zero and above the maximum). Comparing these runs separates payload ordering from command framing, and shows that the read path really returns slave data and that write data does not leak onto MOSI. A slave model checks every bit clocked out and answers reads from a known byte pattern. A cycle-stamping monitor measures the lead, lag, phase lengths and driver release. A held start through one transaction shows both that starts are ignored while busy and that the idle gap before the next transaction is exactly the minimum.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_LAG,
        ST_GAP
    } spim_state_e;

    function automatic int half_up(input int v);
        return (v + 1) / 2;
    endfunction

endpackage

// File: rtl/spim_seq.sv
module spim_seq
    import spim_pkg::*;
#(
    parameter int DIV_SYS   = 4,
    parameter int LEAD_SYS  = 11,
    parameter int GAP_SYS   = 3,
    parameter int MAX_BYTES = 4,
    localparam int BI_W     = $clog2(MAX_BYTES + 1),
    localparam int NB_W     = BI_W + 1,
    localparam int TX_W     = 8 * MAX_BYTES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [6:0]      addr_i,
    input  logic            rw_i,
    input  logic [TX_W-1:0] wr_data_i,
    input  logic [NB_W-1:0] nbytes_i,
    output logic            sck_o,
    output logic            cs_n_o,
    output logic            mosi_o,
    output logic            mosi_oe_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            rise_o,
    output logic            last_bit_o,
    output logic            rd_byte_o
);

    localparam int HALF_HI  = half_up(DIV_SYS);
    localparam int HALF_LO  = DIV_SYS - HALF_HI;
    localparam int EDGE_CYC = LEAD_SYS + HALF_HI;
    localparam int CNT_W    = $clog2(EDGE_CYC + GAP_SYS + DIV_SYS + 1);

    typedef struct packed {
        spim_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic             sck;
        logic             cs_n;
        logic             oe;
        logic             done;
        logic             rw;
        logic [2:0]       bitn;
        logic [BI_W-1:0]  byte_i;
        logic [BI_W-1:0]  last_i;
        logic [7:0]       sh;
        logic [TX_W-1:0]  tx;
    } seq_t;

    seq_t q, d;
    logic [BI_W-1:0] neff;
    logic            accept;

    always_comb begin
        if (nbytes_i == '0)
            neff = BI_W'(1);
        else if (nbytes_i > NB_W'(MAX_BYTES))
            neff = BI_W'(MAX_BYTES);
        else
            neff = nbytes_i[BI_W-1:0];
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        accept = start_i && ((q.state == ST_IDLE) ||
                             (q.state == ST_GAP && q.cnt == '0));
        if (accept) begin
            d.state  = ST_LEAD;
            d.cs_n   = 1'b0;
            d.oe     = 1'b1;
            d.cnt    = CNT_W'(EDGE_CYC - 1);
            d.rw     = rw_i;
            d.bitn   = '0;
            d.byte_i = '0;
            d.last_i = neff;
            d.sh     = {addr_i, rw_i};
            d.tx     = wr_data_i;
        end else begin
            case (q.state)
                ST_LEAD: begin
                    if (q.cnt == '0) begin
                        d.state = ST_SHIFT;
                        d.sck   = 1'b1;
                        d.cnt   = CNT_W'(HALF_HI - 1);
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - 1'b1;
                    end else if (q.sck) begin
                        d.sck = 1'b0;
                        if (q.bitn == 3'd7) begin
                            if (q.byte_i == q.last_i) begin
                                d.state = ST_LAG;
                                d.oe    = 1'b0;
                                d.cnt   = CNT_W'(EDGE_CYC - 1);
                            end else begin
                                d.byte_i = q.byte_i + 1'b1;
                                d.bitn   = '0;
                                d.sh     = q.rw ? 8'h00 : q.tx[7:0];
                                d.tx     = q.tx >> 8;
                                d.cnt    = CNT_W'(HALF_LO - 1);
                            end
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.cnt  = CNT_W'(HALF_LO - 1);
                        end
                    end else begin
                        d.sck = 1'b1;
                        d.cnt = CNT_W'(HALF_HI - 1);
                    end
                end
                ST_LAG: begin
                    if (q.cnt == '0) begin
                        d.state = ST_GAP;
                        d.cs_n  = 1'b1;
                        d.done  = 1'b1;
                        d.cnt   = CNT_W'(GAP_SYS - 1);
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (q.cnt == '0)
                        d.state = ST_IDLE;
                    else
                        d.cnt = q.cnt - 1'b1;
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.state  <= ST_IDLE;
            q.cs_n   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck_o      = q.sck;
    assign cs_n_o     = q.cs_n;
    assign mosi_o     = q.sh[7];
    assign mosi_oe_o  = q.oe;
    assign done_o     = q.done;
    assign busy_o     = !((q.state == ST_IDLE) ||
                          (q.state == ST_GAP && q.cnt == '0));
    assign rise_o     = (q.state == ST_SHIFT) && !q.sck && (q.cnt == '0);
    assign last_bit_o = (q.bitn == 3'd7);
    assign rd_byte_o  = q.rw && (q.byte_i != '0);

endmodule

// File: rtl/spim_rx.sv
module spim_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_i,
    input  logic       last_bit_i,
    input  logic       keep_i,
    input  logic       miso_i,
    output logic [7:0] rd_data_o,
    output logic       rd_valid_o
);

    typedef struct packed {
        logic [7:0] sh;
        logic [7:0] data;
        logic       valid;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (sample_i) begin
            d.sh = {q.sh[6:0], miso_i};
            if (last_bit_i && keep_i) begin
                d.data  = {q.sh[6:0], miso_i};
                d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data_o  = q.data;
    assign rd_valid_o = q.valid;

endmodule

// File: rtl/spi_guard_master.sv
module spi_guard_master #(
    parameter int DIV_SYS   = 4,
    parameter int LEAD_SYS  = 11,
    parameter int GAP_SYS   = 3,
    parameter int MAX_BYTES = 4,
    localparam int BI_W     = $clog2(MAX_BYTES + 1),
    localparam int NB_W     = BI_W + 1,
    localparam int TX_W     = 8 * MAX_BYTES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [6:0]      addr_i,
    input  logic            rw_i,
    input  logic [TX_W-1:0] wr_data_i,
    input  logic [NB_W-1:0] nbytes_i,
    output logic [7:0]      rd_data_o,
    output logic            rd_valid_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            sck_o,
    output logic            cs_n_o,
    output logic            mosi_o,
    output logic            mosi_oe_o,
    input  logic            miso_i
);

    logic rise_w;
    logic last_bit_w;
    logic rd_byte_w;

    spim_seq #(
        .DIV_SYS  (DIV_SYS),
        .LEAD_SYS (LEAD_SYS),
        .GAP_SYS  (GAP_SYS),
        .MAX_BYTES(MAX_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .addr_i    (addr_i),
        .rw_i      (rw_i),
        .wr_data_i (wr_data_i),
        .nbytes_i  (nbytes_i),
        .sck_o     (sck_o),
        .cs_n_o    (cs_n_o),
        .mosi_o    (mosi_o),
        .mosi_oe_o (mosi_oe_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .rise_o    (rise_w),
        .last_bit_o(last_bit_w),
        .rd_byte_o (rd_byte_w)
    );

    spim_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  (rise_w),
        .last_bit_i(last_bit_w),
        .keep_i    (rd_byte_w),
        .miso_i    (miso_i),
        .rd_data_o (rd_data_o),
        .rd_valid_o(rd_valid_o)
    );

endmodule

// File: rtl/spim_chk.sv
module spim_chk (
    input logic clk,
    input logic rst_n,
    input logic sck_o,
    input logic cs_n_o,
    input logic mosi_o,
    input logic mosi_oe_o,
    input logic busy_o,
    input logic done_o,
    input logic rd_valid_o
);

    p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o);

    p_oe_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mosi_oe_o |-> !cs_n_o);

    p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && $past(!cs_n_o) && mosi_oe_o && !$fell(sck_o)) |-> $stable(mosi_o));

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_at_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> done_o);

    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);

    p_cs_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);

endmodule

bind spi_guard_master spim_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_o     (sck_o),
    .cs_n_o    (cs_n_o),
    .mosi_o    (mosi_o),
    .mosi_oe_o (mosi_oe_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rd_valid_o(rd_valid_o)
);

// File: tb/spi_guard_master_tb.sv
module spi_guard_master_tb_top;

    localparam int CLK_P     = 10;
    localparam int DIV_SYS   = 4;
    localparam int LEAD_SYS  = 11;
    localparam int GAP_SYS   = 3;
    localparam int MAX_BYTES = 4;
    localparam int NB_W      = $clog2(MAX_BYTES + 1) + 1;
    localparam int TX_W      = 8 * MAX_BYTES;
    localparam int HH        = (DIV_SYS + 1) / 2;
    localparam int HL        = DIV_SYS - HH;
    localparam int EDGE      = LEAD_SYS + HH;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [6:0]      addr_i = '0;
    logic            rw_i = 1'b0;
    logic [TX_W-1:0] wr_data_i = '0;
    logic [NB_W-1:0] nbytes_i = '0;
    logic [7:0]      rd_data_o;
    logic            rd_valid_o, busy_o, done_o, sck_o, cs_n_o, mosi_o, mosi_oe_o;
    logic            miso_i = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_P / 2) clk = ~clk;

    spi_guard_master #(
        .DIV_SYS(DIV_SYS), .LEAD_SYS(LEAD_SYS), .GAP_SYS(GAP_SYS), .MAX_BYTES(MAX_BYTES)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .rw_i(rw_i),
        .wr_data_i(wr_data_i), .nbytes_i(nbytes_i), .rd_data_o(rd_data_o),
        .rd_valid_o(rd_valid_o), .busy_o(busy_o), .done_o(done_o), .sck_o(sck_o),
        .cs_n_o(cs_n_o), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .miso_i(miso_i)
    );

    // monitor and slave model state
    int cyc = 0;
    int cs_fall_cyc, cs_rise_cyc, first_rise_cyc, last_fall_cyc, oe_fall_cyc;
    int hi_start, lo_start, last_gap;
    int rises = 0, xfer_cnt = 0, done_cnt = 0, rd_cnt = 0;
    int phase_err = 0, idle_err = 0, mosi_err = 0, done_err = 0;
    logic p_cs = 1'b1, p_sck = 1'b0, p_oe = 1'b0, p_mosi = 1'b0;
    logic [7:0] sl_rx [8];
    logic [7:0] rd_buf [8];

    function automatic logic [7:0] resp(input int k);
        return 8'(8'h3C ^ (k * 8'h17));
    endfunction

    function automatic logic stream_bit(input int i);
        logic [7:0] b;
        b = (i / 8 == 0) ? 8'hC3 : resp(i / 8);
        return b[7 - (i % 8)];
    endfunction

    always @(posedge clk) begin
        #1;
        cyc++;
        if (rst_n) begin
            if (p_cs && !cs_n_o) begin
                cs_fall_cyc = cyc;
                last_gap    = cyc - cs_rise_cyc;
                rises       = 0;
                rd_cnt      = 0;
                xfer_cnt++;
                for (int i = 0; i < 8; i++) sl_rx[i] = 8'h00;
                miso_i = stream_bit(0);
            end
            if (!p_cs && cs_n_o) cs_rise_cyc = cyc;
            if (!p_sck && sck_o) begin
                if (rises == 0) first_rise_cyc = cyc;
                else if (cyc - lo_start != HL) phase_err++;
                if (rises < 64) sl_rx[rises / 8][7 - (rises % 8)] = mosi_o;
                rises++;
                hi_start = cyc;
            end
            if (p_sck && !sck_o) begin
                last_fall_cyc = cyc;
                if (cyc - hi_start != HH) phase_err++;
                lo_start = cyc;
                miso_i = stream_bit(rises);
            end
            if (p_oe && !mosi_oe_o) oe_fall_cyc = cyc;
            if (cs_n_o && sck_o) idle_err++;
            if (p_oe && mosi_oe_o && !p_cs && !cs_n_o && (mosi_o != p_mosi) && !(p_sck && !sck_o))
                mosi_err++;
            if (done_o) begin
                done_cnt++;
                if (!(cs_n_o && !p_cs)) done_err++;
            end
            if (rd_valid_o && rd_cnt < 8) begin
                rd_buf[rd_cnt] = rd_data_o;
                rd_cnt++;
            end
        end
        p_cs = cs_n_o; p_sck = sck_o; p_oe = mosi_oe_o; p_mosi = mosi_o;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic launch(input logic [6:0] a, input logic rw, input logic [TX_W-1:0] wd,
                          input int n);
        @(negedge clk);
        addr_i = a; rw_i = rw; wr_data_i = wd; nbytes_i = NB_W'(n);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input int target);
        int t = 0;
        while (done_cnt < target && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk("R11 done reached", int'(done_cnt >= target), 1);
        repeat (GAP_SYS + 2) @(negedge clk);
    endtask

    task automatic check_xfer(input logic [6:0] a, input logic rw, input logic [TX_W-1:0] wd,
                              input int ne);
        chk("R2 lead cycles", first_rise_cyc - cs_fall_cyc, EDGE);
        chk("R3 lag cycles", cs_rise_cyc - last_fall_cyc, EDGE);
        chk("R5 pulse count", rises, 8 * (ne + 1));
        chk("R5 phase length errors", phase_err, 0);
        chk("R5 sck high while idle", idle_err, 0);
        chk("R6 command byte", int'(sl_rx[0]), int'({a, rw}));
        for (int k = 1; k <= ne; k++)
            chk(rw ? "R9 mosi zero on read" : "R6 write data byte",
                int'(sl_rx[k]), rw ? 0 : int'(wd[8*(k-1) +: 8]));
        chk("R7 mosi change off falling edge", mosi_err, 0);
        chk("R8 oe release at last fall", oe_fall_cyc, last_fall_cyc);
        chk("R9 read byte count", rd_cnt, rw ? ne : 0);
        if (rw)
            for (int k = 1; k <= ne && k <= 8; k++)
                chk("R9 read data", int'(rd_buf[k-1]), int'(resp(k)));
        chk("R11 done placement", done_err, 0);
        chk("R10 busy released", int'(busy_o), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cs_n", int'(cs_n_o), 1);
        chk("R1 sck", int'(sck_o), 0);
        chk("R1 oe", int'(mosi_oe_o), 0);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 rd_valid", int'(rd_valid_o), 0);
    endtask

    task automatic t_write_multi();
        int base = done_cnt;
        launch(7'h5A, 1'b0, 32'hC0DE_B00B, 2);
        @(negedge clk);
        chk("R10 busy during transfer", int'(busy_o), 1);
        wait_done(base + 1);
        check_xfer(7'h5A, 1'b0, 32'hC0DE_B00B, 2);
    endtask

    task automatic t_write_single();
        int base = done_cnt;
        launch(7'h01, 1'b0, 32'h0000_0080, 1);
        wait_done(base + 1);
        check_xfer(7'h01, 1'b0, 32'h0000_0080, 1);
    endtask

    task automatic t_read();
        int base = done_cnt;
        launch(7'h40, 1'b1, 32'hFFFF_FFFF, 3);
        wait_done(base + 1);
        check_xfer(7'h40, 1'b1, 32'hFFFF_FFFF, 3);
    endtask

    task automatic t_count_clamp();
        int base = done_cnt;
        launch(7'h33, 1'b0, 32'h1122_3344, 0);
        wait_done(base + 1);
        chk("R12 zero count as one byte", rises, 16);
        check_xfer(7'h33, 1'b0, 32'h1122_3344, 1);
        base = done_cnt;
        launch(7'h2C, 1'b1, 32'h0, 7);
        wait_done(base + 1);
        chk("R12 count clamped to max", rises, 8 * (MAX_BYTES + 1));
        check_xfer(7'h2C, 1'b1, 32'h0, MAX_BYTES);
    endtask

    task automatic t_gap_and_ignore();
        int base_x = xfer_cnt;
        int base_d = done_cnt;
        int t = 0;
        @(negedge clk);
        addr_i = 7'h7F; rw_i = 1'b0; wr_data_i = 32'h0000_00A5; nbytes_i = NB_W'(1);
        start_i = 1'b1;
        while (xfer_cnt < base_x + 2 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        start_i = 1'b0;
        chk("R10 starts while busy ignored", xfer_cnt - base_x, 2);
        chk("R4 gap with held start", last_gap, GAP_SYS);
        wait_done(base_d + 2);
        repeat (20) @(negedge clk);
        chk("R10 no extra transfer", xfer_cnt - base_x, 2);
        chk("R11 one done per transfer", done_cnt - base_d, 2);
        check_xfer(7'h7F, 1'b0, 32'h0000_00A5, 1);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_multi();
        t_write_single();
        t_read();
        t_count_clamp();
        t_gap_and_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule